// File: doc/BRIEF.md
# Privilege Access Gate

This block stands in front of a peripheral's register and RAM decode and decides, one access at a time, whether the requester may reach the addressed location. The address space is split into two parts. A fixed window of global control registers (mode configuration, test control, interrupt setup) can only ever be reached by a supervisor-level requester. Everything else, including the command table, the result table and the other registers, is an assignable region. Its protection level follows a single lock bit taken from the mode configuration register.

An access the gate allows is passed on in the same cycle through a forward enable and a forward write enable. An access it refuses is never passed on, so no location changes and no data is returned. The requester instead gets a one-cycle transfer error pulse in the cycle where the decode logic would have acknowledged it. The lock bit sits inside the always-protected window, so user-level code can never clear it.

Top module: `priv_access_gate`

## Requirements
- R1: A strobed access with `acc_super`=1 is forwarded (`fwd_en`=1) and produces no `xfer_err`, whatever the address and the state of `seg_lock`.
- R2: A strobed access with `acc_super`=0 to an address in the global window [`GLOB_BASE`, `GLOB_BASE`+`GLOB_SIZE`) (defaults 0 to 3) is refused, whatever the state of `seg_lock`. This includes a user write aimed at the register that holds the lock bit.
- R3: A strobed access with `acc_super`=0 to an address outside the global window is refused when `seg_lock`=1.
- R4: A strobed access with `acc_super`=0 to an address outside the global window is forwarded when `seg_lock`=0.
- R5: During a refused access, `fwd_en` and `fwd_we` are both 0 in the strobe cycle, so neither a write nor a read reaches the decode.
- R6: `xfer_err` is 1 for exactly one cycle, `ACK_LAT` clock edges after the strobe of a refused access (default 1). A forwarded access produces no `xfer_err`.
- R7: With `acc_req`=0, `fwd_en`, `fwd_we` and, one latency later, `xfer_err` are all 0.
- R8: For a forwarded access, `fwd_we` equals `acc_we` (1 = write, 0 = read).
- R9: While `rst_n` is 0, `xfer_err` is 0, and a refusal already on its way when reset is asserted is dropped.
- R10: The refusal decision uses the value of `seg_lock` in the strobe cycle. Changing `seg_lock` later does not alter an error pulse that is already on its way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_req | input | 1 | Access strobe, one cycle per access |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Word address of the access |
| acc_super | input | 1 | 1 = requester at supervisor level |
| seg_lock | input | 1 | 1 = assignable region restricted to supervisor |
| fwd_en | output | 1 | Access passed on to the register/RAM decode |
| fwd_we | output | 1 | Passed-on access is a write |
| xfer_err | output | 1 | Transfer error acknowledge pulse |

## Verification
The hardest cases to reach from the ports are the ones where the error pulse has already been decided but has not yet appeared. Two inputs can change in that gap: reset can be asserted, or `seg_lock` can flip, and the output must still follow the strobe-cycle decision. The bench builds these cases by hand. It places a refused strobe directly before an asynchronous reset, and it flips the lock bit in the cycle right after a refused strobe. A full sweep of every address under every combination of privilege, direction and lock value also sends refused and forwarded accesses back to back. That checks that each pulse lasts exactly one cycle and is not stretched by the access that follows.

// File: rtl/priv_access_gate.sv
module priv_access_gate #(
  parameter int ADDR_W    = 8,
  parameter int GLOB_BASE = 0,
  parameter int GLOB_SIZE = 4,
  parameter int ACK_LAT   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_req,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_super,
  input  logic              seg_lock,
  output logic              fwd_en,
  output logic              fwd_we,
  output logic              xfer_err
);

  localparam logic [ADDR_W:0] G_LO = (ADDR_W+1)'(GLOB_BASE);
  localparam logic [ADDR_W:0] G_HI = (ADDR_W+1)'(GLOB_BASE + GLOB_SIZE);

  logic in_glob, need_super, deny;

  assign in_glob    = ({1'b0, acc_addr} >= G_LO) && ({1'b0, acc_addr} < G_HI);
  assign need_super = in_glob || seg_lock;
  assign deny       = acc_req && need_super && !acc_super;

  assign fwd_en = acc_req && !deny;
  assign fwd_we = fwd_en && acc_we;

  logic [ACK_LAT-1:0] deny_q;

  generate
    if (ACK_LAT == 1) begin : g_lat1
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) deny_q <= '0;
        else        deny_q <= deny;
    end else begin : g_latn
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) deny_q <= '0;
        else        deny_q <= {deny_q[ACK_LAT-2:0], deny};
    end
  endgenerate

  assign xfer_err = deny_q[ACK_LAT-1];

endmodule

// File: rtl/priv_access_gate_chk.sv
module priv_access_gate_chk #(
  parameter int ADDR_W    = 8,
  parameter int GLOB_BASE = 0,
  parameter int GLOB_SIZE = 4,
  parameter int ACK_LAT   = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_req,
  input logic              acc_we,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_super,
  input logic              seg_lock,
  input logic              fwd_en,
  input logic              fwd_we,
  input logic              xfer_err
);

  logic glob;
  assign glob = (int'(acc_addr) >= GLOB_BASE) && (int'(acc_addr) < GLOB_BASE + GLOB_SIZE);

  assert_super_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && acc_super |-> fwd_en);

  assert_glob_block_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && !acc_super && glob |-> !fwd_en);

  assert_locked_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && !acc_super && !glob && seg_lock |-> !fwd_en);

  assert_open_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && !acc_super && !glob && !seg_lock |-> fwd_en);

  assert_no_write_leak_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_en |-> !fwd_we);

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_req |-> !fwd_en);

  assert_dir_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_en |-> fwd_we == acc_we);

  generate
    if (ACK_LAT == 1) begin : g_lat1
      assert_err_after_deny_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && !fwd_en |=> xfer_err);
      assert_err_only_deny_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_req && !fwd_en) |=> !xfer_err);
    end
  endgenerate

  always_comb
    if (!rst_n) assert_reset_clear_R9: assert (!xfer_err);

endmodule

bind priv_access_gate priv_access_gate_chk #(
  .ADDR_W(ADDR_W), .GLOB_BASE(GLOB_BASE), .GLOB_SIZE(GLOB_SIZE), .ACK_LAT(ACK_LAT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_we(acc_we),
  .acc_addr(acc_addr), .acc_super(acc_super), .seg_lock(seg_lock),
  .fwd_en(fwd_en), .fwd_we(fwd_we), .xfer_err(xfer_err)
);

// File: tb/priv_access_gate_test.sv
module priv_access_gate_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int GB = 0;
  localparam int GS = 4;

  logic clk = 0, rst_n = 0;
  logic acc_req = 0, acc_we = 0, acc_super = 0, seg_lock = 0;
  logic [AW-1:0] acc_addr = '0;
  logic fwd_en, fwd_we, xfer_err;

  int errors = 0, checks = 0;
  bit done = 0;

  priv_access_gate #(.ADDR_W(AW), .GLOB_BASE(GB), .GLOB_SIZE(GS), .ACK_LAT(1)) uut (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_we(acc_we), .acc_addr(acc_addr),
    .acc_super(acc_super), .seg_lock(seg_lock), .fwd_en(fwd_en), .fwd_we(fwd_we),
    .xfer_err(xfer_err));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (addr=%0d super=%0b lock=%0b we=%0b)",
               req, act, exp, acc_addr, acc_super, seg_lock, acc_we);
    end
  endtask

  // drive one cycle at negedge, check forward outputs mid-cycle, error after the edge
  task automatic cycle(input bit req, input bit we, input int addr, input bit sup,
                       input bit lock, input string tag);
    bit glob, refuse;
    @(negedge clk);
    acc_req = req; acc_we = we; acc_addr = AW'(addr); acc_super = sup; seg_lock = lock;
    glob   = (addr >= GB) && (addr < GB + GS);
    refuse = req && !sup && (glob || lock);
    #(CLK_PERIOD/4);
    chk({tag, " fwd_en"}, int'(fwd_en), int'(req && !refuse));
    chk({tag, " fwd_we"}, int'(fwd_we), int'(req && !refuse && we));
    @(posedge clk); #1;
    chk({tag, " xfer_err"}, int'(xfer_err), int'(refuse));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD/4);
    chk("R9 reset xfer_err", int'(xfer_err), 0);
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1;

    cycle(0, 1, 5, 0, 1, "R7 idle");
    cycle(0, 0, 0, 1, 0, "R7 idle");

    // full sweep; each cycle follows the previous one directly
    for (int lk = 0; lk < 2; lk++)
      for (int sp = 0; sp < 2; sp++)
        for (int w = 0; w < 2; w++)
          for (int a = 0; a < (1 << AW); a++) begin
            string t;
            if (sp == 1) t = "R1 super";
            else if (a >= GB && a < GB + GS) t = "R2/R5 glob";
            else if (lk == 1) t = "R3/R5 locked";
            else t = "R4/R8 open";
            cycle(1, w[0], a, sp[0], lk[0], t);
          end

    // R2: user write at lock-bit register with lock clear
    cycle(1, 1, 0, 0, 0, "R2 cfg write");
    // R6: pulse is one cycle wide
    cycle(1, 0, GB + 1, 0, 0, "R6 deny");
    cycle(0, 0, 0, 0, 0, "R6 width");
    cycle(1, 0, 100, 0, 1, "R6 deny");
    cycle(1, 0, 100, 1, 1, "R6 super after deny");

    // R10: lock flips after refused strobe; pulse still appears
    @(negedge clk);
    acc_req = 1; acc_we = 1; acc_addr = 8'd50; acc_super = 0; seg_lock = 1;
    @(posedge clk); #1;
    seg_lock = 0; acc_req = 0;
    chk("R10 pulse despite lock change", int'(xfer_err), 1);
    @(posedge clk); #1;
    chk("R10 pulse ends", int'(xfer_err), 0);

    // R9: refused strobe then reset before its pulse shows
    @(negedge clk);
    acc_req = 1; acc_we = 0; acc_addr = 8'd2; acc_super = 0; seg_lock = 0;
    #1 rst_n = 0;
    @(posedge clk); #1;
    chk("R9 pending pulse dropped", int'(xfer_err), 0);
    @(negedge clk) begin rst_n = 1; acc_req = 0; end
    @(posedge clk); #1;
    chk("R9 quiet after reset", int'(xfer_err), 0);
    cycle(1, 1, 9, 0, 1, "R3 after reset");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule